// File: doc/BRIEF.md
# Cam Edge Crank-Angle Capture

This block records the crank angle at which one chosen transition of the raw camshaft trigger signal occurs. The result is used to measure the position of a cam phaser. An engine-position tracker supplies the current absolute angle as a tick count and a flag that says whether it is synchronized. The block watches the cam input, which is already synchronized to the clock, for the selected polarity of transition. A programmable angle window, given as a first and a last tick, hides every other transition of a multi-tooth cam pattern.

When a transition of the selected polarity lands inside the open window while the tracker is synchronized, the block latches the tick count that is present in that cycle and raises a one-cycle valid strobe. Only the first such transition in each opening of the window is taken. If the window closes without a capture, a missed-edge flag is raised. The window may span the end of the cycle: a first tick larger than the last tick means the window wraps through tick zero. Converting ticks to degrees and closing the control loop happen outside this block.

Top module: `cam_edge_capture`

## Requirements
- R1: After reset, capAngle is 0, capValid is 0 and missedFlag is 0.
- R2: With selRise = 1, a rising transition (camIn sampled 1 in a cycle after being sampled 0 in the cycle before) inside the open window loads capAngle with the angleTick of the cycle in which camIn was first sampled 1. The new value appears one clock later.
- R3: With selRise = 0, a falling transition (camIn sampled 0 after 1) is captured in the same way, and rising transitions are ignored.
- R4: When winStart <= winEnd, the window is open for winStart <= angleTick <= winEnd, both ends included. Transitions outside it change neither capAngle nor capValid.
- R5: When winStart > winEnd, the window is open for angleTick >= winStart or angleTick <= winEnd, so it wraps through tick 0.
- R6: Only the first qualifying transition in each opening of the window is captured. Later ones are ignored until the window closes and opens again.
- R7: capValid is high for exactly one clock cycle each time capAngle is loaded, and it is low at all other times.
- R8: missedFlag goes to 1 one clock after the window closes (open in one cycle, closed in the next, while synchronized) with no capture in that opening. A later capture clears it.
- R9: While syncOk is 0, missedFlag is cleared one clock later, and the pending capture state is dropped. A window that is open when sync returns counts as a fresh opening.
- R10: Transitions that occur while syncOk is 0 are never captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| syncOk | input | 1 | Position tracker is synchronized |
| angleTick | input | TICK_W | Current absolute crank angle in ticks |
| camIn | input | 1 | Raw cam trigger level, already synchronized to clk |
| selRise | input | 1 | 1 captures rising transitions, 0 captures falling transitions |
| winStart | input | TICK_W | First tick of the capture window |
| winEnd | input | TICK_W | Last tick of the capture window |
| capAngle | output | TICK_W | Latched angle of the last captured transition |
| capValid | output | 1 | One-cycle strobe when capAngle updates |
| missedFlag | output | 1 | Window closed without a capture |

## Verification
Every result is due one clock after the cycle that causes it. A capture shows on capAngle and capValid one clock after camIn is first sampled at its new level. The missed flag rises one clock after the first cycle outside the window, and it clears one clock after syncOk is sampled low. The bench drives inputs on the falling edge and lets a behavioural model step on each rising edge from those same inputs. It compares all three outputs at the next falling edge, and that is the point where each result becomes due. Directed checks at the end of each revolution confirm the captured angle, the number of strobes, and the missed flag against values worked out from the cam pattern.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic load;     // latch the current angle
    logic setMiss;  // window closed without capture
    logic clrMiss;  // sync lost
  } capStrobe_t;
endpackage

// File: rtl/cam_capture_ctl.sv
module cam_capture_ctl
  import cam_capture_pkg::*;
#(
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syncOk,
  input  logic [TICK_W-1:0] angleTick,
  input  logic              camIn,
  input  logic              selRise,
  input  logic [TICK_W-1:0] winStart,
  input  logic [TICK_W-1:0] winEnd,
  output capStrobe_t        strobes
);
  logic camPrev;
  logic winPrev;
  logic gotEdge;
  logic edgeHit;
  logic inWin;
  logic winNow;
  logic closeEv;
  logic wraps;

  assign wraps = winStart > winEnd;

  always_comb begin
    if (wraps) inWin = (angleTick >= winStart) || (angleTick <= winEnd);
    else       inWin = (angleTick >= winStart) && (angleTick <= winEnd);
  end

  assign edgeHit = selRise ? (camIn & ~camPrev) : (~camIn & camPrev);
  assign winNow  = syncOk & inWin;
  assign closeEv = syncOk & winPrev & ~inWin;

  always_comb begin
    strobes.load    = winNow & edgeHit & ~gotEdge;
    strobes.setMiss = closeEv & ~gotEdge;
    strobes.clrMiss = ~syncOk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      camPrev <= 1'b0;
      winPrev <= 1'b0;
      gotEdge <= 1'b0;
    end else begin
      camPrev <= camIn;
      winPrev <= winNow;
      if (!winNow)          gotEdge <= 1'b0;
      else if (strobes.load) gotEdge <= 1'b1;
    end
  end

  // one capture per opening: two loads can never be adjacent
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> !strobes.load);

  // no capture strobe is issued in a cycle following sync loss
  p_no_load_nosync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !syncOk |=> !($past(strobes.load) && !$past(syncOk)));
endmodule

// File: rtl/cam_capture_dp.sv
module cam_capture_dp
  import cam_capture_pkg::*;
#(
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] angleIn,
  input  capStrobe_t        strobes,
  output logic [TICK_W-1:0] capAngle,
  output logic              capValid,
  output logic              missedFlag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capAngle   <= '0;
      capValid   <= 1'b0;
      missedFlag <= 1'b0;
    end else begin
      capValid <= strobes.load;
      if (strobes.load) capAngle <= angleIn;
      if (strobes.clrMiss || strobes.load) missedFlag <= 1'b0;
      else if (strobes.setMiss)           missedFlag <= 1'b1;
    end
  end

  p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (capValid && capAngle == $past(angleIn)));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capValid |=> !capValid);

  p_miss_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.setMiss && !strobes.clrMiss) |=> missedFlag);

  p_miss_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrMiss |=> !missedFlag);
endmodule

// File: rtl/cam_edge_capture.sv
module cam_edge_capture
  import cam_capture_pkg::*;
#(
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              syncOk,
  input  logic [TICK_W-1:0] angleTick,
  input  logic              camIn,
  input  logic              selRise,
  input  logic [TICK_W-1:0] winStart,
  input  logic [TICK_W-1:0] winEnd,
  output logic [TICK_W-1:0] capAngle,
  output logic              capValid,
  output logic              missedFlag
);
  capStrobe_t strobes;

  cam_capture_ctl #(.TICK_W(TICK_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .syncOk(syncOk), .angleTick(angleTick),
    .camIn(camIn), .selRise(selRise), .winStart(winStart), .winEnd(winEnd),
    .strobes(strobes)
  );

  cam_capture_dp #(.TICK_W(TICK_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .angleIn(angleTick), .strobes(strobes),
    .capAngle(capAngle), .capValid(capValid), .missedFlag(missedFlag)
  );
endmodule

// File: tb/cam_edge_capture_test.sv
module cam_edge_capture_test;
  localparam int TW  = 12;
  localparam int REV = 720;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic syncOk = 1'b0;
  logic [TW-1:0] angleTick = '0;
  logic camIn = 1'b0;
  logic selRise = 1'b1;
  logic [TW-1:0] winStart = '0;
  logic [TW-1:0] winEnd = '0;
  logic [TW-1:0] capAngle;
  logic capValid;
  logic missedFlag;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cycles = 0;
  int angle = 0;
  int dropLo = -1;
  int dropHi = -1;
  string tag = "R1";

  // behavioural reference state
  int  mCap = 0;
  bit  mValid = 0, mMiss = 0, mPrevCam = 0, mWasOpen = 0, mTaken = 0;

  always #10 clk = ~clk;

  cam_edge_capture #(.TICK_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .syncOk(syncOk), .angleTick(angleTick),
    .camIn(camIn), .selRise(selRise), .winStart(winStart), .winEnd(winEnd),
    .capAngle(capAngle), .capValid(capValid), .missedFlag(missedFlag)
  );

  function automatic bit pat(int a);
    return (a >= 100 && a < 150) || (a >= 300 && a < 340) || (a >= 600 && a < 700);
  endfunction

  function automatic bit openAt(int a, int s, int e);
    if (s <= e) return a >= s && a <= e;
    return a >= s || a <= e;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mCap = 0; mValid = 0; mMiss = 0; mPrevCam = 0; mWasOpen = 0; mTaken = 0;
    end else begin
      bit open, hit, cam;
      cam  = camIn;
      open = syncOk && openAt(int'(angleTick), int'(winStart), int'(winEnd));
      hit  = selRise ? (cam && !mPrevCam) : (!cam && mPrevCam);
      mValid = 0;
      if (!syncOk) begin
        mMiss = 0; mTaken = 0; mWasOpen = 0;
      end else begin
        if (open && hit && !mTaken) begin
          mCap = int'(angleTick); mValid = 1; mMiss = 0; mTaken = 1;
        end else if (mWasOpen && !open && !mTaken) begin
          mMiss = 1;
        end
        if (!open) mTaken = 0;
        mWasOpen = open;
      end
      mPrevCam = cam;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareModel();
    check(capAngle == TW'(mCap), tag, "capAngle vs model", int'(capAngle), mCap);
    check(capValid == mValid, tag, "capValid vs model", int'(capValid), int'(mValid));
    check(missedFlag == mMiss, tag, "missedFlag vs model", int'(missedFlag), int'(mMiss));
  endtask

  // one clock: compare at falling edge, then drive the next tick
  task automatic step();
    @(negedge clk);
    compareModel();
    if (capValid) pulses++;
    angleTick = TW'(angle);
    camIn = pat(angle);
    syncOk = !(angle == 0 || (angle >= dropLo && angle < dropHi));
    angle = (angle + 1) % REV;
  endtask

  task automatic runRev(string t, bit rise, int s, int e);
    tag = t; selRise = rise; winStart = TW'(s); winEnd = TW'(e);
    pulses = 0;
    for (int i = 0; i < REV; i++) step();
    step();  // let the result of tick 719 become visible
    angle = (angle + REV - 1) % REV;  // keep revolutions aligned
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(capAngle == 0, "R1", "reset capAngle", int'(capAngle), 0);
    check(capValid == 0, "R1", "reset capValid", int'(capValid), 0);
    check(missedFlag == 0, "R1", "reset missedFlag", int'(missedFlag), 0);
    rst_n = 1'b1;

    runRev("R2", 1, 50, 200);
    check(capAngle == 100, "R2", "rising capture", int'(capAngle), 100);
    check(pulses == 1, "R2", "strobe count", pulses, 1);

    runRev("R3", 0, 50, 200);
    check(capAngle == 150, "R3", "falling capture", int'(capAngle), 150);
    runRev("R3", 0, 250, 320);
    check(pulses == 0, "R3", "rising ignored in fall mode", pulses, 0);
    check(capAngle == 150, "R3", "capAngle held", int'(capAngle), 150);

    runRev("R4", 1, 250, 350);
    check(capAngle == 300, "R4", "in-window capture", int'(capAngle), 300);
    runRev("R8", 1, 101, 299);
    check(pulses == 0, "R4", "edges on both sides of window ignored", pulses, 0);
    check(missedFlag == 1, "R8", "miss after empty window", int'(missedFlag), 1);
    step();  // tick 0 has sync low
    step();
    check(missedFlag == 0, "R9", "miss cleared by sync loss", int'(missedFlag), 0);
    for (int i = 2; i < REV; i++) step();
    step();
    angle = (angle + REV - 1) % REV;

    runRev("R5", 1, 650, 120);
    check(capAngle == 100, "R5", "wrapped window rising", int'(capAngle), 100);
    runRev("R5", 0, 650, 120);
    check(capAngle == 700, "R5", "wrapped window falling", int'(capAngle), 700);
    check(pulses == 1, "R7", "one strobe per capture", pulses, 1);

    runRev("R6", 1, 50, 400);
    check(capAngle == 100, "R6", "first edge kept", int'(capAngle), 100);
    check(pulses == 1, "R6", "second edge ignored", pulses, 1);

    dropLo = 80; dropHi = 121;
    runRev("R10", 1, 50, 400);
    check(capAngle == 300, "R10", "edge during sync loss skipped", int'(capAngle), 300);
    check(pulses == 1, "R10", "strobe count", pulses, 1);
    dropLo = -1; dropHi = -1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule